// File: doc/BRIEF.md
# Baudot Teleprinter Output Decoder

This block sits on the transmit side of a five-level teleprinter channel. The processor hands it one 5-bit Baudot code at a time through an I/O pulse interface. The block translates each code into a 7-bit ASCII character and offers that character on a ready/valid port to whatever drives the line. It also keeps a done flag that the processor can test and clear.

Baudot carries two character sets, letters and figures, in the same five bits. The block tracks which set is active. Two reserved codes switch the set: octal 033 selects figures and octal 037 selects letters. These codes change only the internal state and never reach the output port. All other codes go through a 64-entry table. The table index is the code, with the active set as bit 5. An entry of zero marks a code that has no character. Such a code completes silently.

Character pacing and serial framing belong to the downstream stage.

Top module: `baudot_tx_decoder`

## Requirements
- R1: Reset is synchronous and active-low. After reset `done_flag` is 0, `ch_valid` is 0 and `fig_mode` is 0 (letters).
- R2: `iot_pulse` bit 2 is the load pulse. At the clock edge it is sampled, it captures `iot_data[4:0]` as the pending code and clears `done_flag`. A printable code shows on `ch_valid`/`ch_data` right after that edge.
- R3: In letters mode the ASCII output includes these pairs: code 1 gives 0x54 ('T'), code 3 gives 0x4F ('O'), code 8 gives 0x0A (line feed) and code 24 gives 0x41 ('A').
- R4: Code 27 (octal 033) sets figures mode one cycle after it is loaded. It sets `done_flag` and never raises `ch_valid`. In figures mode, code 1 gives 0x35 ('5') and code 24 gives 0x2D ('-').
- R5: Code 31 (octal 037) sets letters mode one cycle after it is loaded. It sets `done_flag` and never raises `ch_valid`.
- R6: While `ch_ready` is low, `ch_valid` stays high, `ch_data` stays stable and `done_flag` stays 0.
- R7: When `ch_valid` and `ch_ready` are both high at an edge, the character is taken. `ch_valid` then drops and `done_flag` is 1.
- R8: `iot_skip` is combinational. It equals `iot_pulse` bit 0 AND `done_flag`.
- R9: `iot_pulse` bit 1 clears `done_flag` at the edge. If a code completes on the same edge, the completion wins and the flag is set.
- R10: A code whose table entry is zero completes one cycle after it is loaded. It sets `done_flag` and emits nothing. Code 0 is such an entry in both modes.
- R11: A load that arrives while a code is still pending replaces it. Only the new code is emitted. A replaced shift code has no effect on the mode.
- R12: Bits of `iot_data` above bit 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iot_pulse | input | 3 | I/O pulses: bit 0 tests, bit 1 clears the flag, bit 2 loads |
| iot_data | input | DATA_W (18) | Processor data word; the low 5 bits hold the code |
| iot_skip | output | 1 | Skip response to the test pulse |
| done_flag | output | 1 | Set when the last loaded code has been handled |
| fig_mode | output | 1 | Active character set: 1 for figures, 0 for letters |
| ch_valid | output | 1 | An ASCII character is offered |
| ch_ready | input | 1 | The downstream stage accepts the character |
| ch_data | output | CHAR_W (7) | ASCII character |

## Verification
On every cycle, the embedded assertions check four things:
- A shift code is never offered downstream.
- A stalled character holds its code and keeps the flag clear.
- An accepted character always sets the flag.
- The mode changes only when a shift code completes.

Some behaviours can only be shown by the directed scenarios, because they depend on the contents of the table and on the order of events:
- the actual ASCII values in each mode;
- silent completion of unassigned entries;
- the priority of completion over a clear pulse;
- replacement of a pending code, including a shift code that never takes effect.

// File: rtl/bdo_pkg.sv
// Package: shared constants and the Baudot-to-ASCII table for the decoder.
// The table is indexed by {figures, code} and returns 0 for codes
// that carry no character.
package bdo_pkg;

    localparam int CODE_W = 5;
    localparam int CHAR_W = 7;
    localparam int IDX_W  = CODE_W + 1;

    localparam logic [CODE_W-1:0] CODE_TO_FIG = 5'o33;
    localparam logic [CODE_W-1:0] CODE_TO_LTR = 5'o37;

    // Returns the ASCII character for one table index; zero means unassigned.
    function automatic logic [CHAR_W-1:0] bdo_lookup(input logic [IDX_W-1:0] idx);
        logic [CHAR_W-1:0] ch;
        case (idx)
            // letters set
            6'd1:  ch = 7'h54;  6'd2:  ch = 7'h0D;  6'd3:  ch = 7'h4F;  6'd4:  ch = 7'h20;
            6'd5:  ch = 7'h48;  6'd6:  ch = 7'h4E;  6'd7:  ch = 7'h4D;  6'd8:  ch = 7'h0A;
            6'd9:  ch = 7'h4C;  6'd10: ch = 7'h52;  6'd11: ch = 7'h47;  6'd12: ch = 7'h49;
            6'd13: ch = 7'h50;  6'd14: ch = 7'h43;  6'd15: ch = 7'h56;  6'd16: ch = 7'h45;
            6'd17: ch = 7'h5A;  6'd18: ch = 7'h44;  6'd19: ch = 7'h42;  6'd20: ch = 7'h53;
            6'd21: ch = 7'h59;  6'd22: ch = 7'h46;  6'd23: ch = 7'h58;  6'd24: ch = 7'h41;
            6'd25: ch = 7'h57;  6'd26: ch = 7'h4A;  6'd28: ch = 7'h55;  6'd29: ch = 7'h51;
            6'd30: ch = 7'h4B;
            // figures set
            6'd33: ch = 7'h35;  6'd34: ch = 7'h0D;  6'd35: ch = 7'h39;  6'd36: ch = 7'h20;
            6'd37: ch = 7'h23;  6'd38: ch = 7'h2C;  6'd39: ch = 7'h2E;  6'd40: ch = 7'h0A;
            6'd41: ch = 7'h29;  6'd42: ch = 7'h34;  6'd43: ch = 7'h26;  6'd44: ch = 7'h38;
            6'd45: ch = 7'h30;  6'd46: ch = 7'h3A;  6'd47: ch = 7'h3B;  6'd48: ch = 7'h33;
            6'd49: ch = 7'h22;  6'd50: ch = 7'h24;  6'd51: ch = 7'h3F;  6'd52: ch = 7'h07;
            6'd53: ch = 7'h36;  6'd54: ch = 7'h21;  6'd55: ch = 7'h2F;  6'd56: ch = 7'h2D;
            6'd57: ch = 7'h32;  6'd58: ch = 7'h27;  6'd60: ch = 7'h37;  6'd61: ch = 7'h31;
            6'd62: ch = 7'h28;
            default: ch = '0;
        endcase
        return ch;
    endfunction

endpackage

// File: rtl/bdo_shift_track.sv
// Shift tracker: holds the letters/figures state.
// It flags whether the pending code is one of the two shift codes.
// Assumes shift_apply pulses only on the cycle a shift code completes.
module bdo_shift_track #(
    parameter int CODE_W = bdo_pkg::CODE_W,
    parameter logic [CODE_W-1:0] FIG_CODE = bdo_pkg::CODE_TO_FIG,
    parameter logic [CODE_W-1:0] LTR_CODE = bdo_pkg::CODE_TO_LTR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              shift_apply,
    output logic              is_shift,
    output logic              fig_mode
);

    // Decode the two reserved shift codes.
    always_comb begin
        is_shift = (code == FIG_CODE) || (code == LTR_CODE);
    end

    // Update the active set when a shift code completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fig_mode <= 1'b0;
        end else if (shift_apply) begin
            fig_mode <= (code == FIG_CODE);
        end
    end

    // The mode moves only on a completing shift code (R4, R5).
    p_mode_only_on_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_apply |=> $stable(fig_mode));

endmodule

// File: rtl/bdo_xlate.sv
// Translator: looks up the ASCII character for {mode, code}.
// It reports whether the code emits anything.
// It is purely combinational and assumes the code is held in a register upstream.
module bdo_xlate #(
    parameter int CODE_W = bdo_pkg::CODE_W,
    parameter int CHAR_W = bdo_pkg::CHAR_W,
    localparam int IDX_W = CODE_W + 1
) (
    input  logic              fig_mode,
    input  logic [CODE_W-1:0] code,
    input  logic              is_shift,
    output logic [CHAR_W-1:0] ascii,
    output logic              emits
);

    logic [IDX_W-1:0] idx;

    // Form the table index with the mode as its top bit.
    always_comb begin
        idx = {fig_mode, code};
    end

    // Look up the character; shift codes and zero entries do not emit.
    always_comb begin
        ascii = bdo_pkg::bdo_lookup(idx);
        emits = !is_shift && (ascii != '0);
    end

endmodule

// File: rtl/bdo_ctrl.sv
// Controller: holds the pending code, the done flag and the output handshake.
// A load takes priority over completion.
// A completion takes priority over a clear pulse.
// Assumes code_emits and code_is_shift describe buf_code.
module bdo_ctrl #(
    parameter int CODE_W = bdo_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              clr_req,
    input  logic [CODE_W-1:0] load_code,
    input  logic              code_emits,
    input  logic              code_is_shift,
    input  logic              ch_ready,
    output logic [CODE_W-1:0] buf_code,
    output logic              pending,
    output logic              done,
    output logic              ch_valid,
    output logic              shift_apply
);

    logic finish;

    // Decide whether the pending code completes on this edge.
    always_comb begin
        ch_valid    = pending && code_emits;
        finish      = pending && !load_req && (code_emits ? ch_ready : 1'b1);
        shift_apply = finish && code_is_shift;
    end

    // Update the code buffer, the pending bit and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_code <= '0;
            pending  <= 1'b0;
            done     <= 1'b0;
        end else if (load_req) begin
            buf_code <= load_code;
            pending  <= 1'b1;
            done     <= 1'b0;
        end else if (finish) begin
            pending  <= 1'b0;
            done     <= 1'b1;
        end else if (clr_req) begin
            done     <= 1'b0;
        end
    end

    // A load leaves a pending code and a clear flag (R2).
    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> pending && !done);

    // An offered character never coexists with a set flag (R6).
    p_valid_flag_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |-> !done);

    // A stalled character keeps its code (R6).
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && !ch_ready && !load_req |=> ch_valid && $stable(buf_code));

    // An accepted character sets the flag (R7).
    p_accept_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid && ch_ready && !load_req |=> done && !pending);

endmodule

// File: rtl/baudot_tx_decoder.sv
// Top: decodes the I/O pulses, ties the controller, shift tracker and
// translator together, and answers the skip test.
// Assumes one load per code and a downstream stage that obeys ready/valid.
module baudot_tx_decoder #(
    parameter int DATA_W = 18,
    parameter int CODE_W = bdo_pkg::CODE_W,
    parameter int CHAR_W = bdo_pkg::CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        iot_pulse,
    input  logic [DATA_W-1:0] iot_data,
    output logic              iot_skip,
    output logic              done_flag,
    output logic              fig_mode,
    output logic              ch_valid,
    input  logic              ch_ready,
    output logic [CHAR_W-1:0] ch_data
);

    logic              load_req;
    logic              clr_req;
    logic [CODE_W-1:0] buf_code;
    logic              pending;
    logic              is_shift;
    logic              emits;
    logic              shift_apply;
    logic              unused_hi;

    // Split the pulse bits into requests.
    always_comb begin
        load_req  = iot_pulse[2];
        clr_req   = iot_pulse[1];
        iot_skip  = iot_pulse[0] && done_flag;
        unused_hi = ^iot_data[DATA_W-1:CODE_W];
    end

    bdo_ctrl #(.CODE_W(CODE_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_req      (load_req),
        .clr_req       (clr_req),
        .load_code     (iot_data[CODE_W-1:0]),
        .code_emits    (emits),
        .code_is_shift (is_shift),
        .ch_ready      (ch_ready),
        .buf_code      (buf_code),
        .pending       (pending),
        .done          (done_flag),
        .ch_valid      (ch_valid),
        .shift_apply   (shift_apply)
    );

    bdo_shift_track #(.CODE_W(CODE_W)) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .code        (buf_code),
        .shift_apply (shift_apply),
        .is_shift    (is_shift),
        .fig_mode    (fig_mode)
    );

    bdo_xlate #(.CODE_W(CODE_W), .CHAR_W(CHAR_W)) i_xlate (
        .fig_mode (fig_mode),
        .code     (buf_code),
        .is_shift (is_shift),
        .ascii    (ch_data),
        .emits    (emits)
    );

    // A pending shift code is never offered downstream (R4, R5).
    p_shift_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pending && is_shift |-> !ch_valid);

endmodule

// File: tb/test_baudot_tx_decoder.sv
`timescale 1ns/1ps
module test_baudot_tx_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  iot_pulse = '0;
    logic [17:0] iot_data = '0;
    logic        ch_ready = 1'b0;
    logic        iot_skip, done_flag, fig_mode, ch_valid;
    logic [6:0]  ch_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    baudot_tx_decoder i_baudot_tx_decoder (
        .clk(clk), .rst_n(rst_n), .iot_pulse(iot_pulse), .iot_data(iot_data),
        .iot_skip(iot_skip), .done_flag(done_flag), .fig_mode(fig_mode),
        .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [17:0] word);
        @(negedge clk); iot_pulse = 3'b100; iot_data = word;
        @(negedge clk); iot_pulse = 3'b000;
    endtask

    task automatic accept();
        ch_ready = 1'b1; @(negedge clk); ch_ready = 1'b0;
    endtask

    task automatic send_expect(input logic [4:0] code, input int exp, input string req);
        do_load({13'd0, code});
        chk({req, " valid"}, ch_valid, 1);
        chk({req, " data"}, ch_data, exp);
        chk({req, " done low while offered"}, done_flag, 0);
        accept();
        chk({req, " R7 done after accept"}, done_flag, 1);
        chk({req, " R7 valid drops"}, ch_valid, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 done", done_flag, 0);
        chk("R1 valid", ch_valid, 0);
        chk("R1 letters", fig_mode, 0);
    endtask

    task automatic t_letters();
        send_expect(5'd1, 'h54, "R2 R3 T");
        send_expect(5'd3, 'h4F, "R3 O");
        send_expect(5'd8, 'h0A, "R3 LF");
        send_expect(5'd24, 'h41, "R3 A");
    endtask

    task automatic t_figures();
        do_load(18'd27);
        chk("R4 shift silent", ch_valid, 0);
        @(negedge clk);
        chk("R4 done", done_flag, 1);
        chk("R4 figures", fig_mode, 1);
        chk("R4 still silent", ch_valid, 0);
        send_expect(5'd1, 'h35, "R4 five");
        send_expect(5'd24, 'h2D, "R4 dash");
    endtask

    task automatic t_letters_shift();
        do_load(18'd31);
        chk("R5 shift silent", ch_valid, 0);
        @(negedge clk);
        chk("R5 done", done_flag, 1);
        chk("R5 letters", fig_mode, 0);
        send_expect(5'd1, 'h54, "R5 back to T");
    endtask

    task automatic t_stall();
        do_load(18'd16);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6 valid held", ch_valid, 1);
            chk("R6 data held", ch_data, 'h45);
            chk("R6 done low", done_flag, 0);
        end
        accept();
        chk("R7 done after stall", done_flag, 1);
    endtask

    task automatic t_skip_clear();
        @(negedge clk); iot_pulse = 3'b001; #1;
        chk("R8 skip with done", iot_skip, 1);
        iot_pulse = 3'b010; #1;
        chk("R8 no skip without test", iot_skip, 0);
        @(negedge clk); iot_pulse = 3'b000;
        chk("R9 clear", done_flag, 0);
        iot_pulse = 3'b001; #1;
        chk("R8 no skip when clear", iot_skip, 0);
        iot_pulse = 3'b000;
    endtask

    task automatic t_clear_vs_finish();
        do_load(18'd5);
        chk("R9 pending H", ch_data, 'h48);
        ch_ready = 1'b1; iot_pulse = 3'b010;
        @(negedge clk); ch_ready = 1'b0; iot_pulse = 3'b000;
        chk("R9 completion wins", done_flag, 1);
    endtask

    task automatic t_unassigned();
        do_load(18'd0);
        chk("R10 letters zero silent", ch_valid, 0);
        @(negedge clk);
        chk("R10 letters zero done", done_flag, 1);
        do_load(18'd27); @(negedge clk);
        do_load(18'd0);
        chk("R10 figures zero silent", ch_valid, 0);
        @(negedge clk);
        chk("R10 figures zero done", done_flag, 1);
        chk("R10 mode kept", fig_mode, 1);
        do_load(18'd31); @(negedge clk);
    endtask

    task automatic t_overwrite();
        do_load(18'd1);
        do_load(18'd24);
        chk("R11 replaced data", ch_data, 'h41);
        accept();
        chk("R11 done", done_flag, 1);
        @(negedge clk);
        chk("R11 no second char", ch_valid, 0);
        @(negedge clk); iot_pulse = 3'b100; iot_data = 18'd27;
        @(negedge clk); iot_data = 18'd1;
        @(negedge clk); iot_pulse = 3'b000;
        chk("R11 shift dropped", fig_mode, 0);
        chk("R11 new char", ch_data, 'h54);
        accept();
    endtask

    task automatic t_upper_bits();
        send_expect(5'd0, 'h0, "dummy") ; // replaced below
    endtask

    task automatic t_upper();
        do_load(18'o777701);
        chk("R12 valid", ch_valid, 1);
        chk("R12 low bits only", ch_data, 'h54);
        accept();
    endtask

    initial begin
        t_reset();
        t_letters();
        t_figures();
        t_letters_shift();
        t_stall();
        t_skip_clear();
        t_clear_vs_finish();
        t_unassigned();
        t_overwrite();
        t_upper();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule